// File: doc/BRIEF.md
# Slot-Indexed Event Fragment Builder

This block accepts a decoded, word-wide frame stream that repeats one all-zero separator followed by a fixed number of channel slots (18 by default). The position of a word after the separator alone decides which channel it belongs to. Each non-empty slot word is written into that channel's own partition of a shared buffer, so interleaved traffic from many channels is sorted into one contiguous fragment per channel.

A fragment opens with a header word (top nibble 0xA) and closes with a trailer word (top nibble 0xC). When a trailer is stored, the channel number and the fragment's word count are queued in a small length FIFO, and a one-cycle completion strobe is raised. A downstream reader pops the FIFO and fetches the stored words through a synchronous read port. Loss of frame alignment and partition overflow are reported as sticky error flags.

Top module: `slot_fragment_builder`

## Requirements
- R1: After reset the block is hunting for alignment, `sync_err` and `ovf_err` are zero, `len_valid` and `frag_done` are low.
- R2: While hunting, every non-zero input word is discarded; the first all-zero word aligns the block, and the next 18 accepted words are slots 0 to 17, after which a separator is expected.
- R3: A word in slot k is written only into partition k.
- R4: An all-zero word in a channel slot is not stored and leaves the channel's write position unchanged.
- R5: A header word (bits 31:28 = 0xA) is written at address 0 of its partition and restarts that partition's write position; later words of the fragment go to consecutive addresses.
- R6: A stored trailer word (bits 31:28 = 0xC) pushes {channel, word count including header and trailer} into the length FIFO, and `frag_done` is high for exactly the following cycle with `frag_chan` set to that channel.
- R7: A non-zero, non-header word in a channel with no open fragment is discarded.
- R8: A non-zero word where the separator is expected sets `sync_err`, which stays set until reset; words are then discarded until the next all-zero word, which realigns the block with the following word as slot 0.
- R9: A word that would be written past the 64th address of a partition is dropped and sets that channel's bit of `ovf_err`, which stays set; a trailer dropped this way pushes nothing.
- R10: The length FIFO is first-in first-out with its head shown on `len_chan`/`len_count` while `len_valid` is high; `len_pop` removes the head; a push into a full FIFO (8 entries) is discarded.
- R11: `rd_data` returns the word at partition `rd_chan`, address `rd_addr` one clock after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 32 | Decoded frame word |
| len_pop | input | 1 | Remove the length FIFO head |
| len_valid | output | 1 | Length FIFO holds at least one entry |
| len_chan | output | 5 | Channel of the head entry |
| len_count | output | 7 | Word count of the head entry |
| frag_done | output | 1 | One-cycle fragment completion strobe |
| frag_chan | output | 5 | Channel of the completed fragment |
| sync_err | output | 1 | Sticky frame alignment error |
| ovf_err | output | 18 | Sticky per-channel partition overflow |
| rd_chan | input | 5 | Read partition select |
| rd_addr | input | 6 | Read address within the partition |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions take for granted that reset is held for at least two clock edges, so that every history they look back on starts from reset values, and that `len_pop` is only meaningful while the FIFO holds an entry. They also assume the reader keeps `rd_chan` below 18. The stimulus holds reset for five cycles, pops only after confirming `len_valid`, and reads only partitions that exist, while random frames are mixed with directed runs that misplace a separator, overfill one partition and overfill the length FIFO.

// File: rtl/slot_fragment_builder.sv
module slot_fragment_builder #(
  parameter int NUM_CH    = 18,
  parameter int DW        = 32,
  parameter int DEPTH     = 64,
  parameter int LEN_DEPTH = 8,
  parameter logic [3:0] HDR_TAG = 4'hA,
  parameter logic [3:0] TRL_TAG = 4'hC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [DW-1:0]                 in_word,
  input  logic                          len_pop,
  output logic                          len_valid,
  output logic [$clog2(NUM_CH)-1:0]     len_chan,
  output logic [$clog2(DEPTH):0]        len_count,
  output logic                          frag_done,
  output logic [$clog2(NUM_CH)-1:0]     frag_chan,
  output logic                          sync_err,
  output logic [NUM_CH-1:0]             ovf_err,
  input  logic [$clog2(NUM_CH)-1:0]     rd_chan,
  input  logic [$clog2(DEPTH)-1:0]      rd_addr,
  output logic [DW-1:0]                 rd_data
);
  localparam int CHW = $clog2(NUM_CH);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = PW + 1;
  localparam int SW  = $clog2(NUM_CH + 1);
  localparam int LW  = $clog2(LEN_DEPTH);
  localparam logic [SW-1:0] SEP_POS = SW'(NUM_CH);
  localparam logic [CW-1:0] FULL_PTR = CW'(DEPTH);

  logic           hunt;
  logic [SW-1:0]  slot;
  logic [CW-1:0]  wptr [NUM_CH];
  logic [NUM_CH-1:0] open_q;
  logic [DW-1:0]  mem [NUM_CH][DEPTH];

  wire            word_zero = (in_word == '0);
  wire [3:0]      tag       = in_word[DW-1 -: 4];
  wire            is_hdr    = (tag == HDR_TAG);
  wire            is_trl    = (tag == TRL_TAG);
  wire            in_slot   = in_valid && !hunt && (slot < SEP_POS);
  wire [CHW-1:0]  ch        = slot[CHW-1:0];
  wire [CW-1:0]   cur_ptr   = wptr[ch];
  wire            room      = (cur_ptr < FULL_PTR);
  wire            take      = in_slot && !word_zero && (is_hdr || open_q[ch]);
  wire            wr_en     = take && (is_hdr || room);
  wire [PW-1:0]   wr_addr   = is_hdr ? '0 : cur_ptr[PW-1:0];
  wire            push_req  = wr_en && is_trl;
  wire [CW-1:0]   new_count = {1'b0, wr_addr} + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hunt     <= 1'b1;
      slot     <= '0;
      sync_err <= 1'b0;
    end else if (in_valid) begin
      if (hunt) begin
        if (word_zero) begin
          hunt <= 1'b0;
          slot <= '0;
        end
      end else if (slot == SEP_POS) begin
        if (word_zero) slot <= '0;
        else begin
          sync_err <= 1'b1;
          hunt     <= 1'b1;
        end
      end else begin
        slot <= slot + SW'(1);
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    wire hit = in_slot && !word_zero && (ch == CHW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wptr[g]    <= '0;
        open_q[g]  <= 1'b0;
        ovf_err[g] <= 1'b0;
      end else if (hit) begin
        if (is_hdr) begin
          wptr[g]   <= CW'(1);
          open_q[g] <= 1'b1;
        end else if (open_q[g]) begin
          if (wptr[g] < FULL_PTR) begin
            wptr[g] <= wptr[g] + CW'(1);
            if (is_trl) open_q[g] <= 1'b0;
          end else begin
            ovf_err[g] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[ch][wr_addr] <= in_word;
    rd_data <= mem[rd_chan][rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frag_done <= 1'b0;
      frag_chan <= '0;
    end else begin
      frag_done <= push_req;
      if (push_req) frag_chan <= ch;
    end
  end

  logic [CHW-1:0] lf_ch  [LEN_DEPTH];
  logic [CW-1:0]  lf_cnt [LEN_DEPTH];
  logic [LW-1:0]  lf_rp, lf_wp;
  logic [LW:0]    lf_fill;

  wire do_push = push_req && (lf_fill != (LW+1)'(LEN_DEPTH));
  wire do_pop  = len_pop && (lf_fill != '0);

  function automatic logic [LW-1:0] step(input logic [LW-1:0] p);
    return (p == LW'(LEN_DEPTH - 1)) ? '0 : p + LW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lf_rp   <= '0;
      lf_wp   <= '0;
      lf_fill <= '0;
    end else begin
      if (do_push) begin
        lf_ch[lf_wp]  <= ch;
        lf_cnt[lf_wp] <= new_count;
        lf_wp         <= step(lf_wp);
      end
      if (do_pop) lf_rp <= step(lf_rp);
      lf_fill <= lf_fill + (LW+1)'(do_push) - (LW+1)'(do_pop);
    end
  end

  assign len_valid = (lf_fill != '0);
  assign len_chan  = lf_ch[lf_rp];
  assign len_count = lf_cnt[lf_rp];

  // R8
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_err) |-> sync_err);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err & $past(ovf_err)) == $past(ovf_err));

  // R6
  done_follows_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_done |-> $past(in_valid));

  // R6
  done_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_done |-> len_valid);

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lf_fill <= (LW+1)'(LEN_DEPTH));

  // R10
  fifo_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(len_valid) |-> $past(len_pop));
endmodule

// File: tb/test_slot_fragment_builder.sv
module test_slot_fragment_builder;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 18;
  localparam int DEPTH = 64;
  localparam int LDEPTH = 8;

  logic clk = 0, rst_n = 0, in_valid = 0, len_pop = 0;
  logic [31:0] in_word = 0;
  logic len_valid, frag_done, sync_err;
  logic [4:0] len_chan, frag_chan, rd_chan = 0;
  logic [6:0] len_count;
  logic [17:0] ovf_err;
  logic [5:0] rd_addr = 0;
  logic [31:0] rd_data;

  slot_fragment_builder i_slot_fragment_builder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .len_pop(len_pop), .len_valid(len_valid), .len_chan(len_chan),
    .len_count(len_count), .frag_done(frag_done), .frag_chan(frag_chan),
    .sync_err(sync_err), .ovf_err(ovf_err), .rd_chan(rd_chan),
    .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit m_hunt = 1, m_sync = 0;
  int m_slot = 0;
  int m_ptr [NCH];
  bit m_open [NCH];
  bit [17:0] m_ovf = 0;
  logic [31:0] m_mem [NCH][DEPTH];
  bit m_wr [NCH][DEPTH];
  int q_ch [$];
  int q_cnt [$];
  int mode = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  task automatic send(input logic [31:0] w);
    bit exp_done = 0;
    int exp_ch = 0, c;
    in_valid = 1; in_word = w;
    if (m_hunt) begin
      if (w == 0) begin m_hunt = 0; m_slot = 0; end
    end else if (m_slot == NCH) begin
      if (w == 0) m_slot = 0;
      else begin m_sync = 1; m_hunt = 1; end
    end else begin
      c = m_slot; m_slot++;
      if (w != 0) begin
        if (w[31:28] == 4'hA) begin
          m_mem[c][0] = w; m_wr[c][0] = 1; m_ptr[c] = 1; m_open[c] = 1;
        end else if (m_open[c]) begin
          if (m_ptr[c] < DEPTH) begin
            m_mem[c][m_ptr[c]] = w; m_wr[c][m_ptr[c]] = 1; m_ptr[c]++;
            if (w[31:28] == 4'hC) begin
              m_open[c] = 0; exp_done = 1; exp_ch = c;
              if (q_ch.size() < LDEPTH) begin q_ch.push_back(c); q_cnt.push_back(m_ptr[c]); end
            end
          end else m_ovf[c] = 1;
        end
      end
    end
    @(negedge clk);
    chk(frag_done === exp_done, "R6 frag_done", frag_done, exp_done);
    if (exp_done) chk(frag_chan == exp_ch, "R6 frag_chan", frag_chan, exp_ch);
  endtask

  task automatic idle();
    in_valid = 0; in_word = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] gen(int c);
    int r;
    r = $urandom_range(0, 99);
    if (mode == 1) return (c == 5) ? {4'h3, 28'($urandom)} : 32'h0;
    if (!m_open[c]) begin
      if (r < 30) return {4'hA, 28'($urandom)};
      if (r < 36) return {4'h3, 28'($urandom)};
      return 32'h0;
    end
    if (r < 20) return {4'hC, 28'($urandom)};
    if (r < 35) return 32'h0;
    if (r < 38) return {4'hA, 28'($urandom)};
    return {4'h5, 28'($urandom)};
  endfunction

  task automatic send_body();
    for (int c = 0; c < NCH; c++) send(gen(c));
  endtask

  task automatic send_frame();
    send(32'h0);
    send_body();
  endtask

  task automatic frame_one(input int ch, input logic [31:0] w);
    send(32'h0);
    for (int c = 0; c < NCH; c++) send(c == ch ? w : 32'h0);
  endtask

  task automatic pop_check();
    idle();
    chk(len_valid == 1, "R10 len_valid", len_valid, 1);
    chk(len_chan == q_ch[0], "R10 len_chan", len_chan, q_ch[0]);
    chk(len_count == q_cnt[0], "R6 len_count", len_count, q_cnt[0]);
    len_pop = 1;
    @(negedge clk);
    len_pop = 0;
    void'(q_ch.pop_front()); void'(q_cnt.pop_front());
  endtask

  task automatic drain();
    while (q_ch.size() > 0) pop_check();
    idle();
    chk(len_valid == 0, "R10 empty", len_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < NCH; c++) begin
      m_ptr[c] = 0; m_open[c] = 0;
      for (int a = 0; a < DEPTH; a++) m_wr[c][a] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(len_valid == 0, "R1 len_valid", len_valid, 0);
    chk(frag_done == 0, "R1 frag_done", frag_done, 0);
    chk(sync_err == 0, "R1 sync_err", sync_err, 0);
    chk(ovf_err == 0, "R1 ovf_err", ovf_err, 0);

    // R2: words before alignment are dropped
    send(32'hA0000011); send(32'hC0000012); send(32'h30000013);
    idle();
    chk(len_valid == 0, "R2 prealign", len_valid, 0);

    // R4 / R7: zero slot skipped, stray data dropped
    frame_one(3, 32'hA0000300);
    frame_one(4, 32'h30000400);
    frame_one(3, 32'h0);
    frame_one(3, 32'hC0000301);
    idle();
    chk(len_valid == 1 && len_chan == 3, "R3 chan", len_chan, 3);
    chk(len_count == 2, "R4 zero skipped", len_count, 2);
    drain();
    frame_one(4, 32'hC0000401);
    idle();
    chk(len_valid == 0, "R7 stray trailer", len_valid, 0);

    for (int f = 0; f < 60; f++) begin
      send_frame();
      drain();
    end
    chk(sync_err == 0, "R8 no error", sync_err, 0);

    // R9 overflow on channel 5
    frame_one(5, 32'hA0000500);
    mode = 1;
    for (int f = 0; f < 66; f++) send_frame();
    mode = 0;
    frame_one(5, 32'hC0000501);
    idle();
    chk(ovf_err == m_ovf, "R9 ovf_err", ovf_err, m_ovf);
    chk(ovf_err[5] == 1, "R9 ovf ch5", ovf_err[5], 1);
    chk(len_valid == 0, "R9 trailer dropped", len_valid, 0);
    frame_one(5, 32'hA0000510);
    frame_one(5, 32'hC0000511);
    drain();
    chk(ovf_err[5] == 1, "R9 sticky", ovf_err[5], 1);

    // R10 full FIFO
    send(32'h0);
    for (int c = 0; c < NCH; c++) send({4'hA, 4'h0, 8'(c), 16'h1});
    send(32'h0);
    for (int c = 0; c < NCH; c++) send({4'hC, 4'h0, 8'(c), 16'h2});
    idle();
    chk(q_ch.size() == LDEPTH, "R10 model full", q_ch.size(), LDEPTH);
    drain();

    // R8 misplaced separator
    send_frame();
    drain();
    send(32'h00000055);
    send(32'hA0000600); send(32'hC0000601); send(32'h30000602);
    idle();
    chk(sync_err == 1, "R8 sync_err", sync_err, 1);
    chk(len_valid == 0, "R8 discarded", len_valid, 0);
    send(32'h0);
    send_body();
    send(32'h0);
    for (int c = 0; c < NCH; c++) send(c == 7 ? 32'hA0000700 : 32'h0);
    frame_one(7, 32'hC0000701);
    idle();
    chk(len_valid == 1 && len_chan == q_ch[0], "R8 realigned", len_chan, q_ch[0]);
    drain();
    chk(sync_err == 1, "R8 sticky", sync_err, 1);
    for (int f = 0; f < 20; f++) begin send_frame(); drain(); end

    // R3 R5 R11 partition contents
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < DEPTH; a++)
        if (m_wr[c][a]) begin
          rd_chan = 5'(c); rd_addr = 6'(a);
          @(negedge clk);
          chk(rd_data == m_mem[c][a], "R11 R3 R5 memory", rd_data, m_mem[c][a]);
        end
    chk(ovf_err == m_ovf, "R9 final", ovf_err, m_ovf);
    summary();
    $finish;
  end
endmodule